// File: doc/BRIEF.md
# Dual-Channel Temperature Limit Alarm

This block watches two signed 8-bit temperature readings, one from an on-die sensor and one from an external diode. Each reading is checked against its own upper and lower limit. A reading arrives with a one-cycle valid strobe, and only on that strobe are the checks taken. Any violation is recorded in a sticky status word, which keeps the bit until software reads it. An active-low alert output is driven while any status bit is set, unless the alert is masked.

The remote front end also reports two wiring faults: the external sensor is disconnected, or it is shorted to the supply. Both faults go into the same status word and drive the same alert. While the disconnect fault is present, the remote limit checks are held off, because a reading from an open diode means nothing.

The status word is cleared by a read-clear strobe. A bit whose condition is present in the same cycle as the strobe stays set.

Top module: `temp_limit_alarm`

## Requirements
- R1: While reset is asserted and after its release, status reads all zeros and alert_n is 1.
- R2: On a valid strobe, a channel's high bit is set when the reading, taken as two's complement, is strictly greater than that channel's high limit; equality sets nothing.
- R3: On a valid strobe, a channel's low bit is set when the reading, taken as two's complement, is strictly less than that channel's low limit (so 8'hFF, which is -1, is below a limit of 0).
- R4: Status bit positions: bit 0 local high, bit 1 local low, bit 2 remote high, bit 3 remote low, bit 4 remote open, bit 5 remote shorted to supply.
- R5: With the valid strobe low, readings, limits and fault inputs have no effect on status.
- R6: A status bit stays set until a read-clear strobe, regardless of later in-range readings.
- R7: A read-clear strobe replaces status with the conditions flagged in that same cycle, which are zero unless a valid strobe is also present.
- R8: A valid strobe with fault_open high sets bit 4 and suppresses bits 2 and 3 for that reading.
- R9: A valid strobe with fault_short high sets bit 5; the remote limit checks still run.
- R10: alert_n is 0 exactly when status is non-zero and alert_mask is 0; the mask never changes status.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_valid | input | 1 | One-cycle strobe: new readings and fault flags are valid |
| local_temp | input | 8 | On-die reading, two's complement °C |
| remote_temp | input | 8 | External diode reading, two's complement °C |
| local_hi | input | 8 | Local upper limit |
| local_lo | input | 8 | Local lower limit |
| remote_hi | input | 8 | Remote upper limit |
| remote_lo | input | 8 | Remote lower limit |
| fault_open | input | 1 | Remote sensor disconnected |
| fault_short | input | 1 | Remote sensor shorted to supply |
| alert_mask | input | 1 | 1 keeps alert_n high |
| status_clr | input | 1 | Read-clear strobe for the status word |
| status | output | 6 | Sticky flags, layout per R4 |
| alert_n | output | 1 | Active-low alert |

## Verification
Directed readings are placed exactly at each limit, one degree inside it and one degree past it, so that strict comparisons can be told apart from inclusive ones. Readings of -1 against a limit of 0 separate signed comparisons from unsigned ones. A long random run then draws readings within a degree of the limits. It mixes strobes, faults, masks and clears, including a clear in the same cycle as a violation, to separate clear-wins from set-wins ordering. It also uses the open fault together with far out-of-range remote readings, to expose any missing suppression.

// File: rtl/tla_pkg.sv
package tla_pkg;
  localparam int unsigned TLA_NFLAGS = 6;

  typedef enum int unsigned {
    FLG_LOC_HI    = 0,
    FLG_LOC_LO    = 1,
    FLG_REM_HI    = 2,
    FLG_REM_LO    = 3,
    FLG_REM_OPEN  = 4,
    FLG_REM_SHORT = 5
  } tla_flag_e;

  // signed comparisons on sign-extended operands
  function automatic logic tla_above(input int reading, input int limit);
    return reading > limit;
  endfunction

  function automatic logic tla_below(input int reading, input int limit);
    return reading < limit;
  endfunction
endpackage

// File: rtl/tla_channel_cmp.sv
module tla_channel_cmp #(
  parameter int unsigned TEMP_W = 8
) (
  input  logic [TEMP_W-1:0] reading,
  input  logic [TEMP_W-1:0] hi_lim,
  input  logic [TEMP_W-1:0] lo_lim,
  input  logic              chk_en,
  output logic              over,
  output logic              under
);
  import tla_pkg::*;

  int r_i, h_i, l_i;

  always_comb begin
    r_i   = int'($signed(reading));
    h_i   = int'($signed(hi_lim));
    l_i   = int'($signed(lo_lim));
    over  = chk_en && tla_above(r_i, h_i);
    under = chk_en && tla_below(r_i, l_i);
  end
endmodule

// File: rtl/tla_sticky_status.sv
module tla_sticky_status #(
  parameter int unsigned NFLAG = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NFLAG-1:0] set_vec,
  input  logic             clr,
  output logic [NFLAG-1:0] status
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    status <= '0;
    else if (clr)  status <= set_vec;
    else           status <= status | set_vec;
  end
endmodule

// File: rtl/temp_limit_alarm.sv
module temp_limit_alarm #(
  parameter int unsigned TEMP_W = 8
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        rd_valid,
  input  logic [TEMP_W-1:0]           local_temp,
  input  logic [TEMP_W-1:0]           remote_temp,
  input  logic [TEMP_W-1:0]           local_hi,
  input  logic [TEMP_W-1:0]           local_lo,
  input  logic [TEMP_W-1:0]           remote_hi,
  input  logic [TEMP_W-1:0]           remote_lo,
  input  logic                        fault_open,
  input  logic                        fault_short,
  input  logic                        alert_mask,
  input  logic                        status_clr,
  output logic [tla_pkg::TLA_NFLAGS-1:0] status,
  output logic                        alert_n
);
  import tla_pkg::*;

  localparam int unsigned NCH   = 2;
  localparam int unsigned NFLAG = TLA_NFLAGS;

  logic [NCH-1:0][TEMP_W-1:0] ch_read, ch_hi, ch_lo;
  logic [NCH-1:0]             ch_en, ch_over, ch_under;
  logic [NFLAG-1:0]           evt_flags;   // conditions seen this cycle
  logic                       any_flag;

  assign ch_read = {remote_temp, local_temp};
  assign ch_hi   = {remote_hi,   local_hi};
  assign ch_lo   = {remote_lo,   local_lo};
  assign ch_en   = {~fault_open, 1'b1};

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    tla_channel_cmp #(.TEMP_W(TEMP_W)) cmp_i (
      .reading (ch_read[g]),
      .hi_lim  (ch_hi[g]),
      .lo_lim  (ch_lo[g]),
      .chk_en  (ch_en[g]),
      .over    (ch_over[g]),
      .under   (ch_under[g])
    );
  end

  always_comb begin
    evt_flags = '0;
    if (rd_valid) begin
      evt_flags[FLG_LOC_HI]    = ch_over[0];
      evt_flags[FLG_LOC_LO]    = ch_under[0];
      evt_flags[FLG_REM_HI]    = ch_over[1];
      evt_flags[FLG_REM_LO]    = ch_under[1];
      evt_flags[FLG_REM_OPEN]  = fault_open;
      evt_flags[FLG_REM_SHORT] = fault_short;
    end
  end

  tla_sticky_status #(.NFLAG(NFLAG)) sts_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_vec (evt_flags),
    .clr     (status_clr),
    .status  (status)
  );

  assign any_flag = |status;
  assign alert_n  = ~(any_flag & ~alert_mask);
endmodule

// File: rtl/tla_checker.sv
module tla_checker #(
  parameter int unsigned NFLAG = 6
) (
  input logic             clk,
  input logic             rst_n,
  input logic             rd_valid,
  input logic             fault_open,
  input logic             status_clr,
  input logic             alert_mask,
  input logic [NFLAG-1:0] status,
  input logic [NFLAG-1:0] evt_flags,
  input logic             alert_n
);
  assert_quiet_without_valid_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_valid && !status_clr) |=> status == $past(status));

  assert_bits_held_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !status_clr |=> (status & $past(status)) == $past(status));

  assert_set_tracks_events_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !status_clr |=> status == ($past(status) | $past(evt_flags)));

  assert_clear_alone_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (status_clr && !rd_valid) |=> status == '0);

  assert_open_suppress_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && fault_open && status_clr) |=> (status[3:2] == 2'b00 && status[4]));

  assert_mask_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    alert_mask |-> alert_n);

  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (status == '0) |-> alert_n);

  assert_alert_fires_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (status != '0 && !alert_mask) |-> !alert_n);
endmodule

bind temp_limit_alarm tla_checker #(.NFLAG(tla_pkg::TLA_NFLAGS)) chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .rd_valid   (rd_valid),
  .fault_open (fault_open),
  .status_clr (status_clr),
  .alert_mask (alert_mask),
  .status     (status),
  .evt_flags  (evt_flags),
  .alert_n    (alert_n)
);

// File: tb/temp_limit_alarm_tb_top.sv
module temp_limit_alarm_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rd_valid = 1'b0;
  logic [7:0] local_temp = '0, remote_temp = '0;
  logic [7:0] local_hi = '0, local_lo = '0, remote_hi = '0, remote_lo = '0;
  logic       fault_open = 1'b0, fault_short = 1'b0, alert_mask = 1'b0, status_clr = 1'b0;
  logic [5:0] status;
  logic       alert_n;

  int total = 0;
  int bad = 0;
  bit done = 0;
  int unsigned mstat = 0;   // reference status word

  always #10 clk = ~clk;

  temp_limit_alarm dut_i (
    .clk(clk), .rst_n(rst_n), .rd_valid(rd_valid),
    .local_temp(local_temp), .remote_temp(remote_temp),
    .local_hi(local_hi), .local_lo(local_lo),
    .remote_hi(remote_hi), .remote_lo(remote_lo),
    .fault_open(fault_open), .fault_short(fault_short),
    .alert_mask(alert_mask), .status_clr(status_clr),
    .status(status), .alert_n(alert_n)
  );

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  function automatic int sv(input logic [7:0] v);
    return (v >= 128) ? int'(v) - 256 : int'(v);
  endfunction

  // reference: apply one clock of the requirements to mstat
  task automatic model_step();
    int unsigned c = 0;
    if (rd_valid) begin
      if (sv(local_temp) > sv(local_hi)) c += 1;
      if (sv(local_temp) < sv(local_lo)) c += 2;
      if (!fault_open) begin
        if (sv(remote_temp) > sv(remote_hi)) c += 4;
        if (sv(remote_temp) < sv(remote_lo)) c += 8;
      end
      if (fault_open)  c += 16;
      if (fault_short) c += 32;
    end
    mstat = status_clr ? c : (mstat | c);
  endtask

  task automatic tick(input string tag);
    @(posedge clk);
    model_step();
    @(negedge clk);
    chk(tag, int'(status), int'(mstat));
    chk("R10", int'(alert_n), (mstat != 0 && !alert_mask) ? 0 : 1);
  endtask

  task automatic idle();
    rd_valid = 0; status_clr = 0; fault_open = 0; fault_short = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog all requirements actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1", int'(status), 0);
    chk("R1", int'(alert_n), 1);
    rst_n = 1'b1;
    local_hi = 8'd30; local_lo = -8'sd10; remote_hi = 8'd80; remote_lo = 8'd0;
    tick("R1");
    chk("R1", int'(status), 0);

    // R2 strict greater-than
    rd_valid = 1; local_temp = 8'd30; remote_temp = 8'd80; tick("R2");
    chk("R2", int'(status), 0);
    local_temp = 8'd31; tick("R2");
    chk("R4", int'(status), 6'h01);
    idle(); status_clr = 1; tick("R7");
    chk("R7", int'(status), 0);

    // R3 strict less-than, signed
    idle(); rd_valid = 1; local_temp = -8'sd10; remote_temp = 8'd0; tick("R3");
    chk("R3", int'(status), 0);
    local_temp = -8'sd11; tick("R3");
    chk("R3", int'(status), 6'h02);
    idle(); status_clr = 1; tick("R7");
    idle(); rd_valid = 1; local_temp = 8'd0; remote_temp = 8'hFF; tick("R3");
    chk("R3", int'(status), 6'h08);
    remote_temp = 8'd81; tick("R4");
    chk("R4", int'(status), 6'h0C);

    // R5 no strobe, no change
    idle(); local_temp = 8'd120; fault_open = 1; fault_short = 1; tick("R5");
    chk("R5", int'(status), 6'h0C);

    // R6 sticky over in-range readings
    idle(); rd_valid = 1; local_temp = 8'd5; remote_temp = 8'd20; tick("R6");
    chk("R6", int'(status), 6'h0C);

    // R7 clear with condition in same cycle
    status_clr = 1; local_temp = 8'd31; tick("R7");
    chk("R7", int'(status), 6'h01);

    // R8 open fault suppresses remote checks
    idle(); status_clr = 1; rd_valid = 1; fault_open = 1; local_temp = 8'd0;
    remote_temp = 8'd127; tick("R8");
    chk("R8", int'(status), 6'h10);
    status_clr = 1; remote_temp = 8'h80; tick("R8");
    chk("R8", int'(status), 6'h10);

    // R9 short fault keeps remote checks
    idle(); status_clr = 1; rd_valid = 1; fault_short = 1; remote_temp = 8'd127; tick("R9");
    chk("R9", int'(status), 6'h24);

    // R10 mask
    idle(); alert_mask = 1; tick("R10");
    chk("R10", int'(alert_n), 1);
    chk("R10", int'(status), 6'h24);
    alert_mask = 0; tick("R10");
    chk("R10", int'(alert_n), 0);

    // random run near the limits
    for (int i = 0; i < 4000; i++) begin
      local_hi  = 8'($urandom_range(0, 60) - 20);
      local_lo  = 8'(sv(local_hi) - int'($urandom_range(0, 30)));
      remote_hi = 8'($urandom_range(0, 100) - 30);
      remote_lo = 8'(sv(remote_hi) - int'($urandom_range(0, 40)));
      case ($urandom_range(0, 3))
        0: local_temp = 8'(sv(local_hi) + int'($urandom_range(0, 2)) - 1);
        1: local_temp = 8'(sv(local_lo) + int'($urandom_range(0, 2)) - 1);
        default: local_temp = 8'($urandom);
      endcase
      case ($urandom_range(0, 3))
        0: remote_temp = 8'(sv(remote_hi) + int'($urandom_range(0, 2)) - 1);
        1: remote_temp = 8'(sv(remote_lo) + int'($urandom_range(0, 2)) - 1);
        default: remote_temp = 8'($urandom);
      endcase
      rd_valid    = ($urandom_range(0, 2) != 0);
      fault_open  = ($urandom_range(0, 7) == 0);
      fault_short = ($urandom_range(0, 7) == 0);
      alert_mask  = ($urandom_range(0, 5) == 0);
      status_clr  = ($urandom_range(0, 4) == 0);
      tick("R4,R6,R7,R8,R9");
    end

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule